// File: doc/BRIEF.md
# Dual-Threshold Power-Up Sequencer

This controller steers a mixed-signal device through power-up, brown-out and full power loss. It uses two supply comparator flags: a low flag marking the level above which digital logic is reliable, and a higher flag marking the level above which analog circuitry may run. Each raw flag passes through a two-flop synchronizer and a glitch filter. A state machine then decides when the analog section and the outputs are enabled, when the nonvolatile settings are copied into shadow registers, and when the device reports itself ready.

The nonvolatile settings are recalled through a request/done handshake with an external recall engine. Those settings are the serial device address and a programmable supply-low limit. The recall runs once for each full power loss. A dip that stays between the two thresholds keeps the recalled values, and operation resumes without a second recall.

A supply-low alarm and a transmit-fault output follow the supply state. They only trust a converter reading taken while the device is running. A host can read the ready flag and the other status bits from a status register.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, and while the filtered digital flag is low, analogEn=0, outputEn=0, rdyN=1, recallReq=0, hostBusEn=0, vccLowAlarm=1, txFault=1 and devAddr=0xA2. The shadow address, the shadow limit, the loaded flag and recallTimeout are cleared.
- R2: Each raw comparator flag goes through two synchronizer flops and then a filter. The filter accepts a new level only after FILT_LEN consecutive synchronized samples of that level, so a pulse shorter than FILT_LEN cycles has no effect on any output.
- R3: When the filtered analog flag rises after a full power loss, recallReq and analogEn go to 1 while outputEn stays 0 and rdyN stays 1.
- R4: A recallDone pulse accepted while recallReq=1 loads nvAddr and nvLimit into the shadow registers. In the next cycle devAddr=nvAddr, rdyN=0 and outputEn=1.
- R5: If no recallDone arrives within TIMEOUT_CYC cycles of recallReq rising, recallReq drops and the block runs anyway: rdyN=0, recallTimeout=1, devAddr=0xA2. A recallDone that arrives outside a recall has no effect.
- R6: If the analog flag falls while the digital flag stays high, analogEn=0, outputEn=0 and rdyN=1, and devAddr keeps its recalled value. When the analog flag returns, outputEn=1 again without any recallReq.
- R7: A fall of the digital flag clears the shadow registers and recallTimeout. The next analog rise starts a new recall.
- R8: vccLowAlarm is 1 whenever the block is not running. While running it clears only on an adcValid cycle with adcVcc strictly greater than the recalled limit. A reading equal to the limit leaves the alarm set.
- R9: txFault is 1 whenever analogEn=0. The fault latch sets on faultIn only while running with vccLowAlarm=0, and is cleared by faultClr or by a digital-flag fall. Clear wins over set.
- R10: Reading rdAddr=0x6E returns bit0=rdyN, bit1=vccLowAlarm, bit2=txFault, bit3=recallTimeout, bit4=shadow loaded, and bits 7:5=0. Any other rdAddr returns 0.
- R11: hostBusEn is 1 exactly while the block is out of its full-power-loss state, that is, whenever the filtered digital flag has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aboveDigRaw | input | 1 | Raw comparator: supply above digital threshold |
| aboveAnaRaw | input | 1 | Raw comparator: supply above analog threshold |
| recallDone | input | 1 | Recall engine finished; nvAddr/nvLimit valid |
| nvAddr | input | DEV_W | Recalled device address |
| nvLimit | input | LIMIT_W | Recalled supply-low limit |
| adcValid | input | 1 | Converter result strobe |
| adcVcc | input | LIMIT_W | Converter supply reading |
| faultIn | input | 1 | Transmit fault event |
| faultClr | input | 1 | Clears the latched transmit fault |
| rdAddr | input | 8 | Host register read address |
| recallReq | output | 1 | Request to the recall engine |
| analogEn | output | 1 | Analog section enable |
| outputEn | output | 1 | Output drivers enable |
| rdyN | output | 1 | Active-low ready flag |
| hostBusEn | output | 1 | Serial host interface usable |
| devAddr | output | DEV_W | Serial device address in use |
| vccLowAlarm | output | 1 | Supply-low alarm (not maskable) |
| txFault | output | 1 | Transmit-fault output |
| recallTimeout | output | 1 | Recall did not finish in time |
| rdData | output | 8 | Host register read data |

## Verification
A wrong internal state shows up at the ports within one cycle of the filtered flag changing. A stuck state machine leaves rdyN high or outputEn low, and a lost shadow register leaves devAddr at 0xA2 after a recall. A missed brown-out shows as a spurious recallReq when the analog flag returns. Filter or synchronizer faults shift every enable edge by whole cycles, so a cycle-by-cycle comparison of every output against a behavioural model exposes them at the first flag transition.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_DEAD     = 3'd0,
    SEQ_WAIT_ANA = 3'd1,
    SEQ_RECALL   = 3'd2,
    SEQ_RUN      = 3'd3,
    SEQ_BROWN    = 3'd4
  } seqState_t;

  // control to datapath strobes
  typedef struct packed {
    logic clrVolatile;  // full power loss: return shadow state to defaults
    logic loadShadow;   // accepted recall completion
    logic setTimeout;   // recall window expired
    logic running;      // normal operation
    logic belowAna;     // analog section off
  } seqStrobe_t;

  localparam logic [7:0] STATUS_REG_ADDR = 8'h6E;

endpackage

// File: rtl/pwr_flag_filter.sv
module pwr_flag_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cleanOut <= 1'b0;
      runCnt   <= '0;
    end else if (syncB == cleanOut) begin
      runCnt <= '0;
    end else if (runCnt == CNT_LAST) begin
      cleanOut <= syncB;
      runCnt   <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 25000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       digOk,
  input  logic       anaOk,
  input  logic       recallDone,
  output seqStrobe_t stb,
  output logic       recallReq,
  output logic       analogEn,
  output logic       outputEn,
  output logic       rdyN,
  output logic       hostBusEn
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  seqState_t state, stateNext;
  logic [TMR_W-1:0] timer;
  logic anaEff, inRecall, recallAccept, recallExpire;

  assign anaEff       = digOk & anaOk;
  assign inRecall     = (state == SEQ_RECALL);
  assign recallAccept = inRecall & anaEff & recallDone;
  assign recallExpire = inRecall & anaEff & ~recallDone & (timer == TMR_LAST);

  always_comb begin
    stateNext = state;
    if (!digOk) begin
      stateNext = SEQ_DEAD;
    end else begin
      unique case (state)
        SEQ_DEAD:     stateNext = SEQ_WAIT_ANA;
        SEQ_WAIT_ANA: if (anaEff) stateNext = SEQ_RECALL;
        SEQ_RECALL: begin
          if (!anaEff)                          stateNext = SEQ_WAIT_ANA;
          else if (recallAccept || recallExpire) stateNext = SEQ_RUN;
        end
        SEQ_RUN:      if (!anaEff) stateNext = SEQ_BROWN;
        SEQ_BROWN:    if (anaEff)  stateNext = SEQ_RUN;
        default:      stateNext = SEQ_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_DEAD;
      timer <= '0;
    end else begin
      state <= stateNext;
      timer <= inRecall ? timer + 1'b1 : '0;
    end
  end

  always_comb begin
    stb.clrVolatile = (state == SEQ_DEAD);
    stb.loadShadow  = recallAccept;
    stb.setTimeout  = recallExpire;
    stb.running     = (state == SEQ_RUN);
    stb.belowAna    = ~((state == SEQ_RUN) | inRecall);
  end

  assign recallReq = inRecall;
  assign analogEn  = ~stb.belowAna;
  assign outputEn  = stb.running;
  assign rdyN      = ~stb.running;
  assign hostBusEn = ~stb.clrVolatile;
endmodule

// File: rtl/pwr_seq_datapath.sv
module pwr_seq_datapath
  import pwr_seq_pkg::*;
#(
  parameter int             DEV_W            = 8,
  parameter int             LIMIT_W          = 16,
  parameter logic [DEV_W-1:0] DEFAULT_DEV_ADDR = 8'hA2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [DEV_W-1:0]   nvAddr,
  input  logic [LIMIT_W-1:0] nvLimit,
  input  logic               adcValid,
  input  logic [LIMIT_W-1:0] adcVcc,
  input  logic               faultIn,
  input  logic               faultClr,
  input  logic [7:0]         rdAddr,
  output logic [DEV_W-1:0]   devAddr,
  output logic               vccLowAlarm,
  output logic               txFault,
  output logic               recallTimeout,
  output logic [7:0]         rdData
);
  logic [DEV_W-1:0]   shAddr;
  logic [LIMIT_W-1:0] shLimit;
  logic               shLoaded;
  logic               faultLatch;
  logic               vccQualified;

  assign vccQualified = adcValid & (adcVcc > shLimit);

  // shadow copies of the nonvolatile settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shAddr   <= '0;
      shLimit  <= '0;
      shLoaded <= 1'b0;
    end else if (stb.clrVolatile) begin
      shAddr   <= '0;
      shLimit  <= '0;
      shLoaded <= 1'b0;
    end else if (stb.loadShadow) begin
      shAddr   <= nvAddr;
      shLimit  <= nvLimit;
      shLoaded <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                recallTimeout <= 1'b0;
    else if (stb.clrVolatile) recallTimeout <= 1'b0;
    else if (stb.setTimeout)  recallTimeout <= 1'b1;
  end

  // supply-low alarm: forced while not running, cleared by a qualified reading
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             vccLowAlarm <= 1'b1;
    else if (!stb.running) vccLowAlarm <= 1'b1;
    else if (vccQualified) vccLowAlarm <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               faultLatch <= 1'b0;
    else if (stb.clrVolatile || faultClr)    faultLatch <= 1'b0;
    else if (stb.running && !vccLowAlarm && faultIn) faultLatch <= 1'b1;
  end

  assign devAddr = shLoaded ? shAddr : DEFAULT_DEV_ADDR;
  assign txFault = stb.belowAna | faultLatch;

  always_comb begin
    if (rdAddr == STATUS_REG_ADDR)
      rdData = {3'b000, shLoaded, recallTimeout, txFault, vccLowAlarm, ~stb.running};
    else
      rdData = 8'h00;
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int               FILT_LEN         = 4,
  parameter int               TIMEOUT_CYC      = 25000,
  parameter int               DEV_W            = 8,
  parameter int               LIMIT_W          = 16,
  parameter logic [DEV_W-1:0] DEFAULT_DEV_ADDR = 8'hA2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               aboveDigRaw,
  input  logic               aboveAnaRaw,
  input  logic               recallDone,
  input  logic [DEV_W-1:0]   nvAddr,
  input  logic [LIMIT_W-1:0] nvLimit,
  input  logic               adcValid,
  input  logic [LIMIT_W-1:0] adcVcc,
  input  logic               faultIn,
  input  logic               faultClr,
  input  logic [7:0]         rdAddr,
  output logic               recallReq,
  output logic               analogEn,
  output logic               outputEn,
  output logic               rdyN,
  output logic               hostBusEn,
  output logic [DEV_W-1:0]   devAddr,
  output logic               vccLowAlarm,
  output logic               txFault,
  output logic               recallTimeout,
  output logic [7:0]         rdData
);
  localparam int NUM_FLAGS = 2;

  logic [NUM_FLAGS-1:0] rawFlags, cleanFlags;
  seqStrobe_t stb;

  assign rawFlags = {aboveAnaRaw, aboveDigRaw};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_filt
    pwr_flag_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawFlags[i]), .cleanOut(cleanFlags[i])
    );
  end

  pwr_seq_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .digOk(cleanFlags[0]), .anaOk(cleanFlags[1]), .recallDone(recallDone),
    .stb(stb), .recallReq(recallReq), .analogEn(analogEn), .outputEn(outputEn),
    .rdyN(rdyN), .hostBusEn(hostBusEn)
  );

  pwr_seq_datapath #(
    .DEV_W(DEV_W), .LIMIT_W(LIMIT_W), .DEFAULT_DEV_ADDR(DEFAULT_DEV_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .nvAddr(nvAddr), .nvLimit(nvLimit), .adcValid(adcValid), .adcVcc(adcVcc),
    .faultIn(faultIn), .faultClr(faultClr), .rdAddr(rdAddr),
    .devAddr(devAddr), .vccLowAlarm(vccLowAlarm), .txFault(txFault),
    .recallTimeout(recallTimeout), .rdData(rdData)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int               TIMEOUT_CYC      = 25000,
  parameter int               DEV_W            = 8,
  parameter logic [DEV_W-1:0] DEFAULT_DEV_ADDR = 8'hA2
) (
  input logic             clk,
  input logic             rstN,
  input logic             recallReq,
  input logic             analogEn,
  input logic             outputEn,
  input logic             rdyN,
  input logic             hostBusEn,
  input logic [DEV_W-1:0] devAddr,
  input logic             vccLowAlarm,
  input logic             txFault,
  input logic             recallTimeout
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  logic [TMR_W-1:0] reqCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          reqCnt <= '0;
    else if (recallReq) reqCnt <= reqCnt + 1'b1;
    else                reqCnt <= '0;
  end

  // R1
  dead_defaults_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostBusEn |=> (devAddr == DEFAULT_DEV_ADDR) && !recallTimeout);

  // R3
  recall_analog_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> analogEn && rdyN && !outputEn);

  // R5
  recall_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> (reqCnt < TMR_W'(TIMEOUT_CYC)));

  // R6
  run_needs_analog_chk: assert property (@(posedge clk) disable iff (!rstN)
    outputEn |-> analogEn && hostBusEn);

  // R8
  alarm_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdyN && $past(rdyN) |-> vccLowAlarm);

  // R9
  txfault_below_chk: assert property (@(posedge clk) disable iff (!rstN)
    !analogEn |-> txFault);
endmodule

bind pwr_seq_top pwr_seq_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC), .DEV_W(DEV_W), .DEFAULT_DEV_ADDR(DEFAULT_DEV_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .recallReq(recallReq), .analogEn(analogEn),
  .outputEn(outputEn), .rdyN(rdyN), .hostBusEn(hostBusEn), .devAddr(devAddr),
  .vccLowAlarm(vccLowAlarm), .txFault(txFault), .recallTimeout(recallTimeout)
);

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
  localparam int FILT = 4;
  localparam int TO   = 40;

  logic clk = 0;
  logic rstN = 0;
  logic aboveDigRaw = 0, aboveAnaRaw = 0, recallDone = 0, adcValid = 0;
  logic faultIn = 0, faultClr = 0;
  logic [7:0] nvAddr = 0, rdAddr = 0;
  logic [15:0] nvLimit = 0, adcVcc = 0;
  logic recallReq, analogEn, outputEn, rdyN, hostBusEn, vccLowAlarm, txFault, recallTimeout;
  logic [7:0] devAddr, rdData;

  int total = 0, bad = 0, cycles = 0;
  bit sawReq = 0;

  always #10 clk = ~clk;

  pwr_seq_top #(.FILT_LEN(FILT), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rstN(rstN), .aboveDigRaw(aboveDigRaw), .aboveAnaRaw(aboveAnaRaw),
    .recallDone(recallDone), .nvAddr(nvAddr), .nvLimit(nvLimit),
    .adcValid(adcValid), .adcVcc(adcVcc), .faultIn(faultIn), .faultClr(faultClr),
    .rdAddr(rdAddr), .recallReq(recallReq), .analogEn(analogEn), .outputEn(outputEn),
    .rdyN(rdyN), .hostBusEn(hostBusEn), .devAddr(devAddr), .vccLowAlarm(vccLowAlarm),
    .txFault(txFault), .recallTimeout(recallTimeout), .rdData(rdData)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 dead, 1 wait analog, 2 recalling, 3 running, 4 brown-out
  int mState = 0, mTimer = 0;
  bit mS1[2], mS2[2], mF[2];
  int mCnt[2];
  logic [7:0] mAddr = 0;
  logic [15:0] mLimit = 0;
  bit mLoaded = 0, mTo = 0, mAlarm = 1, mFault = 0;
  bit run, below, anaEff, load, tmo;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTimer = 0; mAddr = 0; mLimit = 0; mLoaded = 0; mTo = 0;
      mAlarm = 1; mFault = 0;
      foreach (mF[i]) begin mS1[i] = 0; mS2[i] = 0; mF[i] = 0; mCnt[i] = 0; end
    end else begin
      run = (mState == 3);
      below = !(mState == 2 || mState == 3);
      anaEff = mF[1] && mF[0];
      load = (mState == 2) && anaEff && recallDone;
      tmo = (mState == 2) && anaEff && !recallDone && (mTimer == TO - 1);
      if (mState == 0 || faultClr) mFault = 0;
      else if (run && !mAlarm && faultIn) mFault = 1;
      if (!run) mAlarm = 1;
      else if (adcValid && adcVcc > mLimit) mAlarm = 0;
      if (mState == 0) begin mAddr = 0; mLimit = 0; mLoaded = 0; mTo = 0; end
      else if (load) begin mAddr = nvAddr; mLimit = nvLimit; mLoaded = 1; end
      if (tmo) mTo = 1;
      mTimer = (mState == 2) ? mTimer + 1 : 0;
      if (!mF[0]) mState = 0;
      else case (mState)
        0: mState = 1;
        1: if (anaEff) mState = 2;
        2: if (!anaEff) mState = 1; else if (load || tmo) mState = 3;
        3: if (!anaEff) mState = 4;
        4: if (anaEff) mState = 3;
        default: mState = 0;
      endcase
      foreach (mF[i]) begin
        if (mS2[i] == mF[i]) mCnt[i] = 0;
        else if (mCnt[i] == FILT - 1) begin mF[i] = mS2[i]; mCnt[i] = 0; end
        else mCnt[i]++;
        mS2[i] = mS1[i];
      end
      mS1[0] = aboveDigRaw;
      mS1[1] = aboveAnaRaw;
    end
  end

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      logic mRun, mBelow;
      logic [7:0] expRd;
      mRun = (mState == 3);
      mBelow = !(mState == 2 || mState == 3);
      expRd = (rdAddr == 8'h6E) ? {3'b000, mLoaded, mTo, mBelow | mFault, mAlarm, !mRun} : 8'h00;
      chk("R3", "analogEn", analogEn, !mBelow);
      chk("R3", "recallReq", recallReq, mState == 2);
      chk("R4", "outputEn", outputEn, mRun);
      chk("R6", "rdyN", rdyN, !mRun);
      chk("R11", "hostBusEn", hostBusEn, mState != 0);
      chk("R7", "devAddr", devAddr, mLoaded ? mAddr : 8'hA2);
      chk("R8", "vccLowAlarm", vccLowAlarm, mAlarm);
      chk("R9", "txFault", txFault, mBelow | mFault);
      chk("R5", "recallTimeout", recallTimeout, mTo);
      chk("R10", "rdData", rdData, expRd);
    end
  end

  always @(posedge clk) if (recallReq) sawReq = 1;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic waitReq();
    for (int k = 0; k < 60 && !recallReq; k++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    cyc(2); settle();
    // R1 reset state
    chk("R1", "rdyN", rdyN, 1);
    chk("R1", "devAddr", devAddr, 8'hA2);
    chk("R1", "txFault", txFault, 1);
    chk("R1", "vccLowAlarm", vccLowAlarm, 1);
    chk("R1", "hostBusEn", hostBusEn, 0);
    chk("R1", "analogEn", analogEn, 0);

    // R2 short digital glitch ignored
    @(negedge clk); aboveDigRaw = 1; cyc(3); aboveDigRaw = 0;
    cyc(12); settle();
    chk("R2", "hostBusEn after glitch", hostBusEn, 0);

    // R11 digital level up
    @(negedge clk); aboveDigRaw = 1; cyc(10); settle();
    chk("R11", "hostBusEn", hostBusEn, 1);
    chk("R1", "rdyN below analog", rdyN, 1);
    rdAddr = 8'h6E; settle();
    chk("R10", "status below analog", rdData, 8'h07);

    // R3 analog rise starts a recall
    @(negedge clk); aboveAnaRaw = 1; waitReq(); settle();
    chk("R3", "recallReq", recallReq, 1);
    chk("R3", "outputEn during recall", outputEn, 0);
    cyc(3); nvAddr = 8'h5C; nvLimit = 16'h0200; recallDone = 1;
    @(negedge clk); recallDone = 0; cyc(1); settle();
    chk("R4", "devAddr", devAddr, 8'h5C);
    chk("R4", "rdyN", rdyN, 0);
    chk("R4", "outputEn", outputEn, 1);

    // R9 fault before qualified reading is not latched
    @(negedge clk); faultIn = 1; @(negedge clk); faultIn = 0; cyc(1); settle();
    chk("R9", "txFault unqualified", txFault, 0);
    // R8 equal reading keeps alarm, greater clears it
    @(negedge clk); adcValid = 1; adcVcc = 16'h0200; @(negedge clk); adcValid = 0; cyc(1); settle();
    chk("R8", "alarm at equal", vccLowAlarm, 1);
    @(negedge clk); adcValid = 1; adcVcc = 16'h0201; @(negedge clk); adcValid = 0; cyc(1); settle();
    chk("R8", "alarm cleared", vccLowAlarm, 0);
    @(negedge clk); faultIn = 1; @(negedge clk); faultIn = 0; cyc(1); settle();
    chk("R9", "txFault latched", txFault, 1);
    @(negedge clk); faultClr = 1; @(negedge clk); faultClr = 0; cyc(1); settle();
    chk("R9", "txFault cleared", txFault, 0);
    chk("R10", "status running", rdData, 8'h10);
    rdAddr = 8'h10; settle();
    chk("R10", "other address", rdData, 8'h00);
    rdAddr = 8'h6E;

    // R2 short analog dip ignored while running
    @(negedge clk); aboveAnaRaw = 0; cyc(2); aboveAnaRaw = 1; cyc(12); settle();
    chk("R2", "outputEn after dip", outputEn, 1);

    // R6 brown-out keeps settings, no new recall
    @(negedge clk); aboveAnaRaw = 0; cyc(12); settle();
    chk("R6", "outputEn", outputEn, 0);
    chk("R6", "analogEn", analogEn, 0);
    chk("R6", "rdyN", rdyN, 1);
    chk("R6", "devAddr kept", devAddr, 8'h5C);
    chk("R9", "txFault below analog", txFault, 1);
    sawReq = 0;
    @(negedge clk); aboveAnaRaw = 1; cyc(12); settle();
    chk("R6", "outputEn resumed", outputEn, 1);
    chk("R6", "no new recall", sawReq, 0);
    chk("R8", "alarm re-armed", vccLowAlarm, 1);

    // R7 full power loss
    @(negedge clk); aboveAnaRaw = 0; aboveDigRaw = 0; cyc(14); settle();
    chk("R7", "devAddr default", devAddr, 8'hA2);
    chk("R7", "hostBusEn", hostBusEn, 0);
    @(negedge clk); aboveDigRaw = 1; aboveAnaRaw = 1; waitReq(); settle();
    chk("R7", "new recall", recallReq, 1);

    // R5 recall timeout
    cyc(TO + 10); settle();
    chk("R5", "recallTimeout", recallTimeout, 1);
    chk("R5", "rdyN", rdyN, 0);
    chk("R5", "devAddr", devAddr, 8'hA2);
    chk("R10", "status after timeout", rdData, 8'h0A);
    @(negedge clk); nvAddr = 8'h33; recallDone = 1; @(negedge clk); recallDone = 0; cyc(2); settle();
    chk("R5", "late done ignored", devAddr, 8'hA2);

    @(negedge clk); aboveAnaRaw = 0; aboveDigRaw = 0; cyc(14); settle();
    chk("R7", "timeout cleared", recallTimeout, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule